// File: doc/BRIEF.md
# Line Interrupt to Message Redirector

This block gathers twenty-four line interrupt inputs. It turns each qualifying line event into a single message write addressed to a processor's local interrupt controller. Every line has its own redirection entry, which sets the vector, the destination core, the trigger mode (edge or level), the polarity and a mask bit.

Software reaches the block through a small register port with three registers. An index register at offset 0x00 selects an internal register. A window register at offset 0x10 reads and writes the selected register. An end-of-interrupt register at offset 0x40 releases level-mode lines that are waiting. Messages leave on a valid/ready write channel, one at a time. Line 13 is wired inactive inside the block.

Top module: `irq_msg_hub`

## Requirements
- R1: After reset no message is offered and every redirection entry is masked: the low half of every entry reads 0x00010000.
- R2: Window index 0x00 is the identification register, whose bits 31:24 are writable and whose other bits read 0. Index 0x01 is a read-only version register that reads 0x00170020, with the highest entry number 23 in bits 23:16. Any index that is not populated reads 0 and ignores writes.
- R3: Window index 0x10+2n selects the low half of entry n and 0x11+2n selects its high half. The low half holds the vector in 7:0, delivery status in bit 12 (read-only), active-low polarity in bit 13, remote-IRR in bit 14 (read-only), level trigger in bit 15 and mask in bit 16. The high half holds the destination core ID in bits 31:24, and all of its other bits read 0.
- R4: A message carries address 0xFEE00000 with the destination ID in bits 19:12, and data equal to the 8-bit vector, zero-extended.
- R5: In edge mode, one transition of an unmasked line from inactive to active yields exactly one message. A line that stays active yields no further messages.
- R6: An edge that occurs while the line is masked is dropped. Unmasking a line that is already active sends nothing.
- R7: With active-low polarity, a fall of the raw input is the active transition, and a rise sends nothing.
- R8: In level mode, an active unmasked line sends one message and sets remote-IRR. No further message is sent for that line while remote-IRR is set.
- R9: Writing a vector to the end-of-interrupt register clears remote-IRR on the level-mode lines whose vector matches. A line that is still active then sends again. A vector that does not match has no effect.
- R10: Line 13 never produces a message, whatever its entry holds.
- R11: When several lines request at once, the lowest-numbered line is sent first.
- R12: While valid is high and ready is low, the message address and data stay unchanged, even if software rewrites the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 24 | Raw interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register offset (0x00 index, 0x10 window, 0x40 end-of-interrupt) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| msg_valid | output | 1 | Message write request pending |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The hardest state to reach is a level-mode line that is still active at the moment its remote-IRR is cleared. It must send again for the matching vector and stay silent for any other vector. The bench holds the line high, accepts the first message, and then issues end-of-interrupt writes with a wrong vector and then the right one, watching the message channel after each write. A second hard case is two level lines that go active in the same cycle while ready is held low. Both requests are then present when the issuer picks one, so the ordering shows up at the port.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
    localparam int NUM_LINES  = 24;
    localparam int TIED_LINE  = 13;
    localparam int ADDR_W     = 7;
    localparam logic [6:0] OFS_INDEX  = 7'h00;
    localparam logic [6:0] OFS_WINDOW = 7'h10;
    localparam logic [6:0] OFS_EOI    = 7'h40;
    localparam logic [7:0] IDX_ID     = 8'h00;
    localparam logic [7:0] IDX_VER    = 8'h01;
    localparam logic [7:0] IDX_TABLE  = 8'h10;
    localparam logic [31:0] MSG_BASE  = 32'hFEE0_0000;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       low_act;
        logic [7:0] vec;
    } rte_t;

    localparam rte_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0,
                                   low_act: 1'b0, vec: 8'h00};

    function automatic logic [31:0] version_word(input int lines);
        return {8'h00, 8'(lines - 1), 8'h00, 8'h20};
    endfunction

    function automatic logic [31:0] build_addr(input logic [7:0] dest);
        return MSG_BASE | (32'(dest) << 12);
    endfunction

    function automatic logic [31:0] low_word(input rte_t e, input logic ds,
                                             input logic rirr);
        return {15'b0, e.mask, e.level, rirr, e.low_act, ds, 4'b0, e.vec};
    endfunction
endpackage

// File: rtl/irq_line_ctl.sv
module irq_line_ctl #(
    parameter bit TIED = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    input  logic       mask,
    input  logic       level,
    input  logic       low_act,
    input  logic [7:0] vec,
    input  logic       grant,
    input  logic       eoi_stb,
    input  logic [7:0] eoi_vec,
    output logic       req,
    output logic       rirr
);
    logic active, prev_act, pend, rise, eoi_hit;

    generate
        if (TIED) begin : g_tied
            logic unused_in;
            assign unused_in = raw ^ low_act;
            assign active    = 1'b0;
        end else begin : g_live
            assign active = raw ^ low_act;
        end
    endgenerate

    assign rise    = active & ~prev_act;
    assign eoi_hit = eoi_stb && (eoi_vec == vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_act <= 1'b0;
            pend     <= 1'b0;
            rirr     <= 1'b0;
        end else begin
            prev_act <= active;
            if (!level && rise && !mask) pend <= 1'b1;
            else if (grant)              pend <= 1'b0;
            if (grant && level)          rirr <= 1'b1;
            else if (eoi_hit)            rirr <= 1'b0;
        end
    end

    assign req = level ? (active & ~mask & ~rirr) : pend;

    // R8
    rirr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rirr && !eoi_hit) |=> rirr);
endmodule

// File: rtl/irq_msg_issue.sv
module irq_msg_issue #(
    parameter int N = 24,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [7:0]    vec  [N],
    input  logic [7:0]    dest [N],
    input  logic          msg_ready,
    output logic          msg_valid,
    output logic [31:0]   msg_addr,
    output logic [31:0]   msg_data,
    output logic [LW-1:0] cur_line,
    output logic [N-1:0]  grant
);
    import irq_msg_pkg::*;

    logic [LW-1:0] pick;
    logic          any;

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--)
            if (req[i]) pick = LW'(i);
    end
    assign any = |req;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            cur_line  <= '0;
        end else if (msg_valid) begin
            if (msg_ready) msg_valid <= 1'b0;
        end else if (any) begin
            msg_valid <= 1'b1;
            cur_line  <= pick;
            msg_addr  <= build_addr(dest[pick]);
            msg_data  <= {24'b0, vec[pick]};
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_grant
            assign grant[g] = msg_valid && msg_ready && (cur_line == LW'(g));
        end
    endgenerate

    logic [N-1:0] below;
    assign below = (N'(1) << cur_line) - N'(1);

    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    // R4
    addr_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[31:20] == 12'hFEE && msg_addr[11:0] == 12'h000 && msg_data[31:8] == 24'h0));
    // R11
    low_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> (($past(req) & below) == '0));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
    parameter int N = 24,
    localparam int LW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [6:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [N-1:0]        ds,
    input  logic [N-1:0]        rirr,
    output irq_msg_pkg::rte_t   cfg [N],
    output logic                eoi_stb,
    output logic [7:0]          eoi_vec
);
    import irq_msg_pkg::*;

    logic [7:0] index_q, id_q, win_off;
    logic [LW-1:0] win_line;
    logic in_tbl, win_wr;
    logic [31:0] win_rd;

    assign win_off  = index_q - IDX_TABLE;
    assign win_line = win_off[LW:1];
    assign in_tbl   = (index_q >= IDX_TABLE) && (32'(index_q) < 32'(IDX_TABLE) + 32'(2 * N));
    assign win_wr   = reg_wr && (reg_addr == OFS_WINDOW);
    assign eoi_stb  = reg_wr && (reg_addr == OFS_EOI);
    assign eoi_vec  = reg_wdata[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            id_q    <= '0;
            for (int i = 0; i < N; i++) cfg[i] <= RTE_RESET;
        end else begin
            if (reg_wr && reg_addr == OFS_INDEX) index_q <= reg_wdata[7:0];
            if (win_wr && index_q == IDX_ID)     id_q    <= reg_wdata[31:24];
            for (int i = 0; i < N; i++) begin
                if (win_wr && in_tbl && win_line == LW'(i)) begin
                    if (index_q[0]) begin
                        cfg[i].dest <= reg_wdata[31:24];
                    end else begin
                        cfg[i].vec     <= reg_wdata[7:0];
                        cfg[i].low_act <= reg_wdata[13];
                        cfg[i].level   <= reg_wdata[15];
                        cfg[i].mask    <= reg_wdata[16];
                    end
                end
            end
        end
    end

    always_comb begin
        win_rd = '0;
        if (index_q == IDX_ID)       win_rd = {id_q, 24'b0};
        else if (index_q == IDX_VER) win_rd = version_word(N);
        else if (in_tbl) begin
            for (int i = 0; i < N; i++)
                if (win_line == LW'(i))
                    win_rd = index_q[0] ? {cfg[i].dest, 24'b0}
                                        : low_word(cfg[i], ds[i], rirr[i]);
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_INDEX:  reg_rdata = {24'b0, index_q};
            OFS_WINDOW: reg_rdata = win_rd;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_msg_hub.sv
module irq_msg_hub #(
    parameter int NUM_LINES = irq_msg_pkg::NUM_LINES,
    parameter int TIED_LINE = irq_msg_pkg::TIED_LINE,
    localparam int LW = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr,
    input  logic [6:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data
);
    import irq_msg_pkg::*;

    rte_t                 cfg  [NUM_LINES];
    logic [7:0]           vec  [NUM_LINES];
    logic [7:0]           dest [NUM_LINES];
    logic [NUM_LINES-1:0] req, rirr, grant;
    logic                 eoi_stb;
    logic [7:0]           eoi_vec;
    logic [LW-1:0]        cur_line;

    irq_reg_port #(.N(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ds(req), .rirr(rirr),
        .cfg(cfg), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            assign vec[g]  = cfg[g].vec;
            assign dest[g] = cfg[g].dest;
            irq_line_ctl #(.TIED(g == TIED_LINE)) u_line (
                .clk(clk), .rst(rst), .raw(irq_in[g]), .mask(cfg[g].mask),
                .level(cfg[g].level), .low_act(cfg[g].low_act), .vec(cfg[g].vec),
                .grant(grant[g]), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec),
                .req(req[g]), .rirr(rirr[g])
            );
        end
    endgenerate

    irq_msg_issue #(.N(NUM_LINES)) u_issue (
        .clk(clk), .rst(rst), .req(req), .vec(vec), .dest(dest),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data), .cur_line(cur_line), .grant(grant)
    );

    // R10
    tied_silent_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (cur_line != LW'(TIED_LINE)));
endmodule

// File: tb/irq_msg_hub_test.sv
`timescale 1ns/1ps
module irq_msg_hub_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid, msg_ready = 1'b0;
    logic [31:0] msg_addr, msg_data;
    int total = 0, failed = 0;

    localparam logic [6:0] A_IDX = 7'h00, A_WIN = 7'h10, A_EOI = 7'h40;

    always #2.5 clk = ~clk;

    irq_msg_hub uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    typedef struct packed {
        logic [7:0]  idx;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{8'h00, 32'hA5FF_FFFF, 32'hA500_0000},  // R2 id
        '{8'h01, 32'hFFFF_FFFF, 32'h0017_0020},  // R2 version
        '{8'h10, 32'h0001_F0C3, 32'h0001_A0C3},  // R3 ro bits ignored
        '{8'h11, 32'hFFFF_FFFF, 32'hFF00_0000},  // R3 high half
        '{8'h3F, 32'h1234_5678, 32'h1200_0000},  // R3 last entry high
        '{8'h3E, 32'h0001_00FF, 32'h0001_00FF},  // R3 last entry low
        '{8'h40, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 past table
        '{8'h02, 32'hFFFF_FFFF, 32'h0000_0000}   // R2 unused index
    };

    function automatic logic [31:0] lo_w(input logic [7:0] v, input logic pol,
                                         input logic lvl, input logic msk);
        return {15'b0, msk, lvl, 1'b0, pol, 1'b0, 4'b0, v};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_win(input logic [7:0] idx, output logic [31:0] v);
        wr(A_IDX, {24'b0, idx});
        reg_addr = A_WIN;
        #1 v = reg_rdata;
    endtask

    task automatic prog(input int line, input logic [31:0] lo, input logic [7:0] dst);
        wr(A_IDX, 32'(8'h11 + 2 * line));
        wr(A_WIN, {dst, 24'b0});
        wr(A_IDX, 32'(8'h10 + 2 * line));
        wr(A_WIN, lo);
    endtask

    task automatic expect_msg(input string tag, input logic [31:0] ea, input logic [31:0] ed);
        int c = 0;
        while (!msg_valid && c < 12) begin @(negedge clk); c++; end
        chk(msg_valid == 1'b1, {tag, " valid"}, 32'(msg_valid), 32'd1);
        chk(msg_addr == ea, {tag, " addr"}, msg_addr, ea);
        chk(msg_data == ed, {tag, " data"}, msg_data, ed);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_none(input string tag, input int n);
        bit seen = 0;
        repeat (n) begin @(negedge clk); if (msg_valid) seen = 1; end
        chk(!seen, tag, 32'(seen), 32'd0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    initial begin
        #(5.0 * 100000);
        total++; failed++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(msg_valid == 1'b0, "R1 no message after reset", 32'(msg_valid), 32'd0);
        rd_win(8'h10, v);
        chk(v == 32'h0001_0000, "R1 entry 0 masked", v, 32'h0001_0000);
        rd_win(8'h2E, v);
        chk(v == 32'h0001_0000, "R1 entry 15 masked", v, 32'h0001_0000);

        // R2 R3 table walk
        for (int i = 0; i < 8; i++) begin
            wr(A_IDX, {24'b0, TBL[i].idx});
            wr(A_WIN, TBL[i].wd);
            reg_addr = A_WIN;
            #1 chk(reg_rdata == TBL[i].exp, $sformatf("R2/R3 table row %0d", i), reg_rdata, TBL[i].exp);
        end

        // R5 R4 R12 edge line 5
        prog(5, lo_w(8'h35, 0, 0, 0), 8'h02);
        irq_in[5] = 1'b1;
        begin
            int c = 0;
            while (!msg_valid && c < 12) begin @(negedge clk); c++; end
        end
        chk(msg_valid == 1'b1, "R5 edge raises message", 32'(msg_valid), 32'd1);
        chk(msg_addr == 32'hFEE0_2000, "R4 address carries destination", msg_addr, 32'hFEE0_2000);
        prog(5, lo_w(8'h77, 0, 0, 0), 8'h09);
        chk(msg_valid == 1'b1, "R12 valid held", 32'(msg_valid), 32'd1);
        chk(msg_data == 32'h35, "R12 data held", msg_data, 32'h35);
        chk(msg_addr == 32'hFEE0_2000, "R12 addr held", msg_addr, 32'hFEE0_2000);
        msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
        expect_none("R5 steady line sends once", 8);
        irq_in[5] = 1'b0; @(negedge clk); irq_in[5] = 1'b1;
        expect_msg("R5 second edge new entry", 32'hFEE0_9000, 32'h77);
        irq_in[5] = 1'b0;

        // R6 masked edge
        prog(4, lo_w(8'h44, 0, 0, 1), 8'h01);
        irq_in[4] = 1'b1;
        expect_none("R6 masked edge dropped", 6);
        prog(4, lo_w(8'h44, 0, 0, 0), 8'h01);
        expect_none("R6 unmask while active silent", 6);
        irq_in[4] = 1'b0; @(negedge clk); irq_in[4] = 1'b1;
        expect_msg("R6 later edge delivered", 32'hFEE0_1000, 32'h44);
        irq_in[4] = 1'b0;

        // R7 active-low
        irq_in[3] = 1'b1;
        prog(3, lo_w(8'h33, 1, 0, 0), 8'h05);
        expect_none("R7 high idle is inactive", 5);
        irq_in[3] = 1'b0;
        expect_msg("R7 fall triggers", 32'hFEE0_5000, 32'h33);
        irq_in[3] = 1'b1;
        expect_none("R7 rise silent", 6);

        // R8 R9 level line 9
        prog(9, lo_w(8'h49, 0, 1, 0), 8'h01);
        irq_in[9] = 1'b1;
        expect_msg("R8 level message", 32'hFEE0_1000, 32'h49);
        expect_none("R8 no repeat under remote-IRR", 8);
        rd_win(8'h22, v);
        chk(v == 32'h0000_C049, "R8 remote-IRR reads set", v, 32'h0000_C049);
        wr(A_EOI, 32'h48);
        expect_none("R9 wrong vector ignored", 6);
        wr(A_EOI, 32'h49);
        expect_msg("R9 resend while active", 32'hFEE0_1000, 32'h49);
        irq_in[9] = 1'b0;
        wr(A_EOI, 32'h49);
        expect_none("R9 inactive after EOI silent", 6);
        rd_win(8'h22, v);
        chk(v == 32'h0000_8049, "R9 remote-IRR cleared", v, 32'h0000_8049);

        // R10 tied line
        prog(13, lo_w(8'h5D, 0, 1, 0), 8'h01);
        irq_in[13] = 1'b1;
        expect_none("R10 tied line level silent", 8);
        prog(13, lo_w(8'h5D, 1, 0, 0), 8'h01);
        irq_in[13] = 1'b0;
        expect_none("R10 tied line edge silent", 8);

        // R11 priority
        prog(7, lo_w(8'h27, 0, 1, 0), 8'h04);
        prog(2, lo_w(8'h22, 0, 1, 0), 8'h03);
        irq_in[7] = 1'b1; irq_in[2] = 1'b1;
        expect_msg("R11 lowest line first", 32'hFEE0_3000, 32'h22);
        expect_msg("R11 next line after", 32'hFEE0_4000, 32'h27);
        irq_in[7] = 1'b0; irq_in[2] = 1'b0;
        wr(A_EOI, 32'h22); wr(A_EOI, 32'h27);
        expect_none("R11 idle after release", 6);

        summary();
        $finish;
    end
endmodule